// File: doc/BRIEF.md
# Descriptor Ring DMA Sequencer

This block moves Ethernet frame data between a host and a MAC-side byte stream by walking two rings of buffer descriptors. The descriptors and the frame buffers live in a small internal store that the host reaches through a single-cycle register port. Each descriptor is one 32-bit word. It holds an ownership flag, a wrap flag, per-direction control or error flags, an 8-bit length and a 6-bit byte pointer into the buffer store.

On the transmit side the sequencer takes each descriptor the host has marked ready. It plays the buffer out one byte per cycle, marking the final byte of a frame and whether a CRC should be appended. It then hands the descriptor back by clearing the ready flag. On the receive side it places each incoming frame into the current empty descriptor's buffer and writes back the byte count, which includes the FCS, together with the error flags. It then returns the descriptor to the host.

Each direction halts when it finds no descriptor it may use, and only a host clear-halt command restarts it. A graceful stop lets both directions finish the frame they are working on. Events are sticky and are cleared by writing one. A masked OR of the events drives the interrupt line.

Top module: `dma_ring_seq`

## Requirements
- R1: When transmit is enabled and the current transmit descriptor has its ready flag (bit 31) set, the sequencer emits exactly `length` bytes (bits 23:16) in order, starting at buffer byte `pointer` (bits 5:0) and one per cycle on `tx_valid`/`tx_data`. It then clears the ready flag and advances to the next descriptor.
- R2: `tx_eof` is high only on the final byte of a buffer whose last-in-frame flag (bit 29) is set. `tx_crc` is high only together with `tx_eof` and only when the append-CRC flag (bit 28) is set. Event bit 0 is set on completion only when the interrupt flag (bit 27) is set.
- R3: After the sequencer uses a descriptor whose wrap flag (bit 30) is set, it returns to descriptor 0 of that ring instead of advancing.
- R4: If transmit finds no ready descriptor, it halts, and command-register read bit 0 reads 1. It sends nothing, even after a descriptor is made ready, until the host writes 1 to command bit 0.
- R5: A received frame whose descriptor has its empty flag (bit 31) set is written into that buffer from `pointer` onward. The empty flag is cleared, the length field receives the frame byte count including the FCS, and event bit 1 is set.
- R6: When `rx_err` is high with the last byte, the descriptor's error bit (bit 24) is set, and the descriptor is still consumed and the ring advances.
- R7: If a frame starts while the current receive descriptor is not empty, event bit 2 (busy) is set and reception halts (command read bit 1 = 1). That frame and all later frames are ignored until the host writes 1 to command bit 1.
- R8: A receive frame longer than `MAXLEN` bytes stores only its first `MAXLEN` bytes, writes `MAXLEN` as the length and sets the truncation bit (bit 25). No byte is written beyond the buffer.
- R9: With the graceful-stop control bit (bit 2) set, each direction finishes any frame in progress and then sets its own stop event (bit 3 transmit, bit 4 receive). `stop_done` is high only when both stop events are set.
- R10: Turning a direction on (control bit 0 transmit, bit 1 receive) resets its current descriptor index to 0. Every register and event reads 0 after reset.
- R11: Writing 1 to an event bit clears it. `irq` is the OR of the event bits ANDed with the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register address (0x00 control, 0x01 events, 0x02 mask, 0x03 command/halt status, 0x10+ transmit descriptors, 0x20+ receive descriptors, 0x40-0x7F buffer bytes) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational on host_addr |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_eof | output | 1 | Final byte of frame |
| tx_crc | output | 1 | Append CRC to this frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Final byte of frame (FCS included) |
| rx_err | input | 1 | Frame error, qualified by rx_eof |
| irq | output | 1 | Masked event interrupt |
| stop_done | output | 1 | Both directions report graceful stop |

## Verification
The bench sweeps transmit buffer lengths and every combination of the last, CRC and interrupt flags. It also sweeps receive frame lengths across the truncation boundary, so that a length off by one, a spilled byte or a missing truncation flag shows up as a wrong readback or a broken sentinel. Both rings are kept shorter than their storage. A sequencer that ignored the wrap flag would wander onto an unarmed descriptor and stall. Further directed sequences cover four cases: a transmit halt that must not restart on its own, a busy receive that must ignore frames until cleared, a restart that must return to descriptor 0, and a graceful stop that must wait for a transmit frame spanning two descriptors.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  // descriptor word layout
  localparam int B_OWN   = 31;  // ready (tx) / empty (rx)
  localparam int B_WRAP  = 30;
  localparam int B_LAST  = 29;
  localparam int B_CRC   = 28;
  localparam int B_INT   = 27;
  localparam int B_TRUNC = 25;
  localparam int B_ERR   = 24;
  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 8;
  localparam int PTR_W   = 6;

  // event bits
  localparam int EV_TXF   = 0;
  localparam int EV_RXF   = 1;
  localparam int EV_BSY   = 2;
  localparam int EV_TSTOP = 3;
  localparam int EV_RSTOP = 4;
  localparam int EV_W     = 5;

  // host map
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_EVENT = 8'h01;
  localparam logic [7:0] A_MASK  = 8'h02;
  localparam logic [7:0] A_CMD   = 8'h03;

  typedef enum logic [2:0] {S_OFF, S_IDLE, S_RUN, S_HALT, S_STOP} eng_st_e;
endpackage

// File: rtl/dma_tx_eng.sv
module dma_tx_eng
  import dma_ring_pkg::*;
#(
  parameter int NTX = 4,
  localparam int IW = $clog2(NTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gstop,
  input  logic             clr_halt,
  input  logic             d_own,
  input  logic             d_wrap,
  input  logic             d_last,
  input  logic             d_crc,
  input  logic             d_int,
  input  logic [LEN_W-1:0] d_len,
  input  logic [PTR_W-1:0] d_ptr,
  output logic [IW-1:0]    idx,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             out_valid,
  output logic             out_eof,
  output logic             out_crc,
  output logic             done,
  output logic             done_irq,
  output logic             halted,
  output logic             stop_evt
);
  eng_st_e          st, st_n;
  logic [IW-1:0]    idx_n;
  logic [LEN_W-1:0] cnt, cnt_n;
  logic             infr, infr_n;
  logic             last_byte;

  assign last_byte = ({1'b0, cnt} + 9'd1) >= {1'b0, d_len};

  always_comb begin
    st_n     = st;
    idx_n    = idx;
    cnt_n    = cnt;
    infr_n   = infr;
    done     = 1'b0;
    stop_evt = 1'b0;
    if (!en) begin
      st_n = S_OFF;
    end else begin
      case (st)
        S_OFF: begin
          st_n   = S_IDLE;
          idx_n  = '0;
          infr_n = 1'b0;
        end
        S_IDLE: begin
          if (gstop && !infr) begin
            st_n     = S_STOP;
            stop_evt = 1'b1;
          end else if (d_own) begin
            st_n  = S_RUN;
            cnt_n = '0;
          end else begin
            st_n = S_HALT;
          end
        end
        S_RUN: begin
          if (last_byte) begin
            done   = 1'b1;
            infr_n = !d_last;
            st_n   = S_IDLE;
            idx_n  = (d_wrap || idx == IW'(NTX - 1)) ? '0 : idx + IW'(1);
          end else begin
            cnt_n = cnt + 8'd1;
          end
        end
        S_HALT: begin
          if (gstop && !infr) begin
            st_n     = S_STOP;
            stop_evt = 1'b1;
          end else if (clr_halt) begin
            st_n = S_IDLE;
          end
        end
        S_STOP:  if (!gstop) st_n = S_IDLE;
        default: st_n = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      idx  <= '0;
      cnt  <= '0;
      infr <= 1'b0;
    end else begin
      st   <= st_n;
      idx  <= idx_n;
      cnt  <= cnt_n;
      infr <= infr_n;
    end
  end

  assign out_valid = (st == S_RUN);
  assign rd_ptr    = d_ptr + cnt[PTR_W-1:0];
  assign out_eof   = out_valid && last_byte && d_last;
  assign out_crc   = out_eof && d_crc;
  assign done_irq  = done && d_int;
  assign halted    = (st == S_HALT);

  AST_TX_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && en && !clr_halt && !gstop) |=> (halted && !out_valid)); // R4
  AST_TX_START_IDX0: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF && en) |=> (idx == '0)); // R10
endmodule

// File: rtl/dma_rx_eng.sv
module dma_rx_eng
  import dma_ring_pkg::*;
#(
  parameter int NRX    = 4,
  parameter int MAXLEN = 8,
  localparam int IW = $clog2(NRX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gstop,
  input  logic             clr_halt,
  input  logic             d_own,
  input  logic             d_wrap,
  input  logic [PTR_W-1:0] d_ptr,
  input  logic             in_valid,
  input  logic             in_eof,
  input  logic             in_err,
  output logic [IW-1:0]    idx,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             done,
  output logic [LEN_W-1:0] wb_len,
  output logic             wb_trunc,
  output logic             wb_err,
  output logic             busy_evt,
  output logic             halted,
  output logic             stop_evt
);
  eng_st_e          st, st_n;
  logic [IW-1:0]    idx_n;
  logic [LEN_W-1:0] cnt, cnt_n, pos;
  logic             trunc, trunc_n, mid, mid_n;
  logic             start, accept, fits;

  assign start = in_valid && !mid;
  assign mid_n = in_valid ? !in_eof : mid;
  assign pos   = (st == S_IDLE) ? '0 : cnt;
  assign fits  = int'(pos) < MAXLEN;

  always_comb begin
    st_n     = st;
    idx_n    = idx;
    cnt_n    = cnt;
    trunc_n  = trunc;
    accept   = 1'b0;
    done     = 1'b0;
    busy_evt = 1'b0;
    stop_evt = 1'b0;
    if (!en) begin
      st_n = S_OFF;
    end else begin
      case (st)
        S_OFF: begin
          st_n  = S_IDLE;
          idx_n = '0;
        end
        S_IDLE: begin
          if (gstop && !mid) begin
            st_n     = S_STOP;
            stop_evt = 1'b1;
          end else if (start) begin
            if (d_own) begin
              accept  = 1'b1;
              trunc_n = 1'b0;
              st_n    = S_RUN;
            end else begin
              busy_evt = 1'b1;
              st_n     = S_HALT;
            end
          end
        end
        S_RUN: accept = in_valid;
        S_HALT: begin
          if (gstop && !mid) begin
            st_n     = S_STOP;
            stop_evt = 1'b1;
          end else if (clr_halt) begin
            st_n = S_IDLE;
          end
        end
        S_STOP:  if (!gstop) st_n = S_IDLE;
        default: st_n = S_OFF;
      endcase
      if (accept) begin
        cnt_n = (pos == 8'hFF) ? pos : pos + 8'd1;
        if (!fits) trunc_n = 1'b1;
        if (in_eof) begin
          done  = 1'b1;
          st_n  = S_IDLE;
          idx_n = (d_wrap || idx == IW'(NRX - 1)) ? '0 : idx + IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      idx   <= '0;
      cnt   <= '0;
      trunc <= 1'b0;
      mid   <= 1'b0;
    end else begin
      st    <= st_n;
      idx   <= idx_n;
      cnt   <= cnt_n;
      trunc <= trunc_n;
      mid   <= mid_n;
    end
  end

  assign wr_en    = accept && fits;
  assign wr_ptr   = d_ptr + pos[PTR_W-1:0];
  assign wb_len   = fits ? pos + 8'd1 : 8'(MAXLEN);
  assign wb_trunc = (st == S_RUN && trunc) || !fits;
  assign wb_err   = in_err;
  assign halted   = (st == S_HALT);

  AST_RX_BUSY_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_evt |=> (halted || st == S_OFF)); // R7
  AST_RX_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && d_wrap) |=> (idx == '0)); // R3
  AST_RX_NO_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && in_valid && int'(cnt) >= MAXLEN) |-> !wr_en); // R8
endmodule

// File: rtl/dma_ring_seq.sv
module dma_ring_seq
  import dma_ring_pkg::*;
#(
  parameter int NTX    = 4,
  parameter int NRX    = 4,
  parameter int MAXLEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_eof,
  output logic        tx_crc,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_eof,
  input  logic        rx_err,
  output logic        irq,
  output logic        stop_done
);
  localparam int TXW   = $clog2(NTX);
  localparam int RXW   = $clog2(NRX);
  localparam int BUF_N = 1 << PTR_W;

  logic [2:0]      ctrl, ctrl_n;
  logic [EV_W-1:0] ev, ev_n, ev_set, mask, mask_n;
  logic [31:0]     txd [NTX];
  logic [31:0]     rxd [NRX];
  logic [7:0]      bufm [BUF_N];

  logic wr_ctrl, wr_ev, wr_mask, wr_txd, wr_rxd, wr_buf, tx_clr, rx_clr;
  assign wr_ctrl = host_we && host_addr == A_CTRL;
  assign wr_ev   = host_we && host_addr == A_EVENT;
  assign wr_mask = host_we && host_addr == A_MASK;
  assign wr_txd  = host_we && host_addr[7:4] == 4'h1 && int'(host_addr[3:0]) < NTX;
  assign wr_rxd  = host_we && host_addr[7:4] == 4'h2 && int'(host_addr[3:0]) < NRX;
  assign wr_buf  = host_we && host_addr[7:6] == 2'b01;
  assign tx_clr  = host_we && host_addr == A_CMD && host_wdata[0];
  assign rx_clr  = host_we && host_addr == A_CMD && host_wdata[1];

  logic [TXW-1:0]   tx_idx;
  logic [PTR_W-1:0] tx_rd_ptr;
  logic [31:0]      tx_cur;
  logic             tx_done, tx_done_irq, tx_halted, tx_stop_evt;
  logic [RXW-1:0]   rx_idx;
  logic [PTR_W-1:0] rx_wr_ptr;
  logic [31:0]      rx_cur;
  logic [LEN_W-1:0] rx_wb_len;
  logic             rx_wr_en, rx_done, rx_wb_trunc, rx_wb_err, rx_busy, rx_halted, rx_stop_evt;

  assign tx_cur = txd[tx_idx];
  assign rx_cur = rxd[rx_idx];

  dma_tx_eng #(.NTX(NTX)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(ctrl[0]), .gstop(ctrl[2]), .clr_halt(tx_clr),
    .d_own(tx_cur[B_OWN]), .d_wrap(tx_cur[B_WRAP]), .d_last(tx_cur[B_LAST]),
    .d_crc(tx_cur[B_CRC]), .d_int(tx_cur[B_INT]),
    .d_len(tx_cur[LEN_LSB +: LEN_W]), .d_ptr(tx_cur[PTR_W-1:0]),
    .idx(tx_idx), .rd_ptr(tx_rd_ptr), .out_valid(tx_valid), .out_eof(tx_eof),
    .out_crc(tx_crc), .done(tx_done), .done_irq(tx_done_irq),
    .halted(tx_halted), .stop_evt(tx_stop_evt));

  dma_rx_eng #(.NRX(NRX), .MAXLEN(MAXLEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(ctrl[1]), .gstop(ctrl[2]), .clr_halt(rx_clr),
    .d_own(rx_cur[B_OWN]), .d_wrap(rx_cur[B_WRAP]), .d_ptr(rx_cur[PTR_W-1:0]),
    .in_valid(rx_valid), .in_eof(rx_eof), .in_err(rx_err),
    .idx(rx_idx), .wr_en(rx_wr_en), .wr_ptr(rx_wr_ptr), .done(rx_done),
    .wb_len(rx_wb_len), .wb_trunc(rx_wb_trunc), .wb_err(rx_wb_err),
    .busy_evt(rx_busy), .halted(rx_halted), .stop_evt(rx_stop_evt));

  assign ev_set = {rx_stop_evt, tx_stop_evt, rx_busy, rx_done, tx_done_irq};

  always_comb begin
    ctrl_n = wr_ctrl ? host_wdata[2:0] : ctrl;
    mask_n = wr_mask ? host_wdata[EV_W-1:0] : mask;
    ev_n   = (ev & ~(wr_ev ? host_wdata[EV_W-1:0] : '0)) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '0;
      ev   <= '0;
    end else begin
      ctrl <= ctrl_n;
      mask <= mask_n;
      ev   <= ev_n;
    end
  end

  // descriptor words: engine write-back wins over a host write in the same cycle
  for (genvar g = 0; g < NTX; g++) begin : g_txd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        txd[g] <= '0;
      end else if (tx_done && tx_idx == TXW'(g)) begin
        txd[g][B_OWN] <= 1'b0;
      end else if (wr_txd && host_addr[3:0] == 4'(g)) begin
        txd[g] <= host_wdata;
      end
    end
  end

  for (genvar g = 0; g < NRX; g++) begin : g_rxd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxd[g] <= '0;
      end else if (rx_done && rx_idx == RXW'(g)) begin
        rxd[g] <= {1'b0, rxd[g][B_WRAP], rxd[g][29:26], rx_wb_trunc, rx_wb_err,
                   rx_wb_len, rxd[g][15:0]};
      end else if (wr_rxd && host_addr[3:0] == 4'(g)) begin
        rxd[g] <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_buf)   bufm[host_addr[PTR_W-1:0]] <= host_wdata[7:0];
    if (rx_wr_en) bufm[rx_wr_ptr] <= rx_data;
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_CTRL)                                     host_rdata = {29'b0, ctrl};
    else if (host_addr == A_EVENT)                               host_rdata = {27'b0, ev};
    else if (host_addr == A_MASK)                                host_rdata = {27'b0, mask};
    else if (host_addr == A_CMD)                                 host_rdata = {30'b0, rx_halted, tx_halted};
    else if (host_addr[7:4] == 4'h1 && int'(host_addr[3:0]) < NTX) host_rdata = txd[host_addr[TXW-1:0]];
    else if (host_addr[7:4] == 4'h2 && int'(host_addr[3:0]) < NRX) host_rdata = rxd[host_addr[RXW-1:0]];
    else if (host_addr[7:6] == 2'b01)                            host_rdata = {24'b0, bufm[host_addr[PTR_W-1:0]]};
  end

  assign tx_data   = bufm[tx_rd_ptr];
  assign irq       = |(ev & mask);
  assign stop_done = ev[EV_TSTOP] & ev[EV_RSTOP];

  AST_TX_READY_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !txd[$past(tx_idx)][B_OWN]); // R1
  AST_RX_EMPTY_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rxd[$past(rx_idx)][B_OWN]); // R5
  AST_BUSY_EVENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> ev[EV_BSY]); // R7
endmodule

// File: tb/dma_ring_seq_tb.sv
module dma_ring_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXLEN     = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_valid, tx_eof, tx_crc, irq, stop_done;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;

  int n_tests = 0;
  int n_fail  = 0;

  dma_ring_seq #(.NTX(4), .NRX(4), .MAXLEN(MAXLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_eof(tx_eof), .tx_crc(tx_crc), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err), .irq(irq),
    .stop_done(stop_done));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // transmit stream capture
  logic [7:0] txb [256];
  logic       txe [256];
  logic       txc [256];
  int         txn = 0;
  always @(negedge clk) begin
    if (tx_valid && txn < 256) begin
      txb[txn] = tx_data;
      txe[txn] = tx_eof;
      txc[txn] = tx_crc;
      txn++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input int len, input int seed, input bit err);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = 8'(seed + i);
      rx_eof   = (i == len - 1);
      rx_err   = err && (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
  endtask

  function automatic logic [31:0] mkd(input bit own, input bit wrap, input bit last,
                                      input bit crc, input bit intr, input int len, input int ptr);
    return {own, wrap, last, crc, intr, 3'b0, 8'(len), 10'b0, 6'(ptr)};
  endfunction

  function automatic logic [7:0] pat(input int j);
    return 8'(j * 7 + 3);
  endfunction

  // check a captured transmit buffer starting at capture index b
  task automatic chk_tx(input string req, input int b, input int len, input int ptr,
                        input bit last, input bit crc);
    int bad = 0;
    chk({req, " tx byte count"}, txn - b, len);
    for (int i = 0; i < len; i++) begin
      if (txb[b + i] != pat(ptr + i)) bad++;
      if (txe[b + i] != (last && i == len - 1)) bad++;
      if (txc[b + i] != (last && crc && i == len - 1)) bad++;
    end
    chk({req, " tx bytes/eof/crc mismatches"}, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int b, txi, ri, ptr, exp_len;
    bit last, crc, intr, err;

    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10: reset state
    chk("R10 reset irq", int'(irq), 0);
    chk("R10 reset tx_valid", int'(tx_valid), 0);
    chk("R10 reset stop_done", int'(stop_done), 0);
    hr(8'h00, r); chk("R10 reset ctrl", int'(r), 0);
    hr(8'h01, r); chk("R10 reset events", int'(r), 0);

    for (int j = 0; j < 32; j++) hw(8'h40 + 8'(j), {24'b0, pat(j)});
    hw(8'h00, 32'h3);
    idle(5);
    // R4: empty transmit ring halts
    hr(8'h03, r); chk("R4 tx halted", int'(r[0]), 1);
    chk("R7 rx not halted", int'(r[1]), 0);
    b = txn;
    hw(8'h10, mkd(1, 0, 1, 1, 1, 3, 0));
    idle(20);
    chk("R4 no send before clear-halt", txn - b, 0);
    hw(8'h03, 32'h1);
    idle(20);
    chk_tx("R1 R2 first", b, 3, 0, 1, 1);
    hr(8'h10, r); chk("R1 ready cleared", int'(r[31]), 0);
    hr(8'h01, r); chk("R2 tx event set", int'(r[0]), 1);
    chk("R11 irq masked", int'(irq), 0);
    hw(8'h02, 32'h1);
    chk("R11 irq unmasked", int'(irq), 1);
    hw(8'h01, 32'h1);
    chk("R11 irq after w1c", int'(irq), 0);
    hr(8'h01, r); chk("R11 event cleared", int'(r[0]), 0);

    // R1 R2 R3: two-entry transmit ring (wrap on descriptor 1)
    txi = 1;
    for (int k = 0; k < 8; k++) begin
      last = k[0]; crc = k[1]; intr = k[2];
      b = txn;
      hw(8'h10 + 8'(txi), mkd(1, txi == 1, last, crc, intr, k + 1, k * 3));
      hw(8'h03, 32'h1);
      idle(20);
      chk_tx("R1 R3 sweep", b, k + 1, k * 3, last, crc);
      hr(8'h01, r); chk("R2 interrupt flag event", int'(r[0]), int'(intr));
      hw(8'h01, 32'h1);
      hr(8'h10 + 8'(txi), r); chk("R1 sweep ready cleared", int'(r[31]), 0);
      txi ^= 1;
    end

    // R5 R6 R8 R3: three-entry receive ring (wrap on descriptor 2)
    for (int n = 0; n < 12; n++) begin
      ri = n % 3;
      ptr = 32 + ri * 8;
      err = (n % 4 == 3);
      exp_len = (n + 1 > MAXLEN) ? MAXLEN : n + 1;
      hw(8'h40 + 8'(ptr + 8), 32'hEE);
      hw(8'h20 + 8'(ri), mkd(1, ri == 2, 0, 0, 0, 0, ptr));
      send_rx(n + 1, n * 16, err);
      idle(3);
      hr(8'h20 + 8'(ri), r);
      chk("R5 empty cleared", int'(r[31]), 0);
      chk("R3 wrap kept", int'(r[30]), int'(ri == 2));
      chk("R5 R8 length", int'(r[23:16]), exp_len);
      chk("R8 truncation bit", int'(r[25]), int'(n + 1 > MAXLEN));
      chk("R6 error bit", int'(r[24]), int'(err));
      for (int i = 0; i < exp_len; i++) begin
        hr(8'h40 + 8'(ptr + i), r);
        chk("R5 stored byte", int'(r[7:0]), (n * 16 + i) & 255);
      end
      hr(8'h40 + 8'(ptr + 8), r); chk("R8 no spill", int'(r[7:0]), 8'hEE);
      hr(8'h01, r); chk("R5 rx event", int'(r[1]), 1);
      hw(8'h01, 32'h2);
    end

    // R7: busy on a used descriptor (ring back at descriptor 0)
    send_rx(4, 8'hA0, 0);
    idle(3);
    hr(8'h01, r); chk("R7 busy event", int'(r[2]), 1);
    hr(8'h03, r); chk("R7 rx halted", int'(r[1]), 1);
    hw(8'h20, mkd(1, 0, 0, 0, 0, 0, 32));
    send_rx(3, 8'hB0, 0);
    idle(3);
    hr(8'h20, r); chk("R7 frame ignored while halted", int'(r[31]), 1);
    hw(8'h01, 32'h4);
    hw(8'h03, 32'h2);
    send_rx(5, 8'h50, 0);
    idle(3);
    hr(8'h20, r);
    chk("R7 resumed consume", int'(r[31]), 0);
    chk("R7 resumed length", int'(r[23:16]), 5);

    // R10: restart resets receive index to 0
    hw(8'h20, mkd(1, 0, 0, 0, 0, 0, 32));
    hw(8'h21, mkd(1, 0, 0, 0, 0, 0, 40));
    hw(8'h00, 32'h1);
    hw(8'h00, 32'h3);
    send_rx(2, 8'h60, 0);
    idle(3);
    hr(8'h20, r); chk("R10 restart uses desc 0", int'(r[31]), 0);
    hr(8'h21, r); chk("R10 desc 1 untouched", int'(r[31]), 1);

    // R9: graceful stop waits for a transmit frame spanning two descriptors
    b = txn;
    hw(8'h10 + 8'(txi), mkd(1, txi == 1, 0, 0, 0, 2, 0));
    hw(8'h03, 32'h1);
    idle(15);
    chk("R9 first part sent", txn - b, 2);
    hw(8'h00, 32'h7);
    idle(5);
    hr(8'h01, r);
    chk("R9 rx stop event", int'(r[4]), 1);
    chk("R9 tx waits mid-frame", int'(r[3]), 0);
    chk("R9 stop_done low", int'(stop_done), 0);
    txi ^= 1;
    b = txn;
    hw(8'h10 + 8'(txi), mkd(1, txi == 1, 1, 0, 0, 3, 4));
    hw(8'h03, 32'h1);
    idle(15);
    chk_tx("R9 frame finished", b, 3, 4, 1, 0);
    hr(8'h01, r); chk("R9 tx stop event", int'(r[3]), 1);
    chk("R9 stop_done high", int'(stop_done), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule